// File: doc/BRIEF.md
# USB OUT endpoint transfer completion tracker

This block sequences a single device-side OUT endpoint of a USB device controller at the transaction level. Software arms the endpoint with one pulse on a prime input. The pulse carries the total byte count expected, the maximum packet size and an interrupt-on-complete (IOC) flag. While armed, the block answers each received OUT data packet with ACK and subtracts its length from a residual byte counter. While not armed, it answers every packet with NAK.

A transfer ends in one of three ways. The first is a short packet, meaning a packet below the maximum size, including a zero-length packet. The second is the residual reaching zero after a full-size packet. The third is a packet too long for the residual or the maximum size, which raises a sticky overflow error. At the end of a transfer the endpoint disarms. The sticky interrupt is raised once per transfer when IOC was set, and always on overflow. Software reads the residual and computes the received length as the total minus the residual.

Top module: `usb_out_ep_tracker`

## Requirements
- R1: While not armed (`active_o`=0), a packet on `pkt_valid_i` gets a handshake one cycle later with `hs_valid_o`=1 and `hs_ack_o`=0 (NAK). `residual_o` does not change.
- R2: A `prime_i` pulse while not armed loads the length, maximum size and IOC flag. `active_o` reads 1 from the next cycle on, and `short_o` and `ovf_o` are cleared.
- R3: While armed, a packet whose length is within both the residual and the maximum size is answered one cycle later with `hs_ack_o`=1 (ACK). `residual_o` drops by the packet length.
- R4: An accepted packet shorter than the maximum size ends the transfer. `active_o`=0, `short_o`=1, and `residual_o` keeps the bytes still owed.
- R5: A full-size packet that brings the residual to zero ends the transfer with `short_o`=0. No zero-length packet is needed.
- R6: `irq_o` is set in the cycle after a transfer ends if IOC was set. Packets that do not end the transfer never set it, and with IOC clear a normal end leaves it at 0.
- R7: A packet longer than the residual or the maximum size sets the sticky `ovf_o`, ends the transfer and sets `irq_o` whatever the IOC flag. `residual_o` is left unchanged.
- R8: `irq_o` stays set until `irq_clr_i` is pulsed. If a new completion coincides with the clear, `irq_o` stays 1.
- R9: `prime_i` while armed is ignored. The residual and the maximum size in use are kept.
- R10: A zero-length packet while armed with a nonzero residual ends the transfer as a short packet.
- R11: After any end of transfer, further packets are NAKed until the endpoint is primed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prime_i | input | 1 | Arm request pulse |
| prime_len_i | input | LEN_W | Total bytes of the transfer |
| prime_mps_i | input | MPS_W | Maximum packet size |
| prime_ioc_i | input | 1 | Interrupt on completion |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt |
| pkt_valid_i | input | 1 | One-cycle pulse: an OUT data packet was received |
| pkt_len_i | input | MPS_W | Byte count of that packet |
| hs_valid_o | output | 1 | Handshake decision valid |
| hs_ack_o | output | 1 | 1 = ACK, 0 = NAK |
| active_o | output | 1 | Endpoint armed (prime bit readback) |
| residual_o | output | LEN_W | Bytes still owed |
| short_o | output | 1 | Last transfer ended on a short packet |
| ovf_o | output | 1 | Sticky overflow error |
| irq_o | output | 1 | Sticky completion interrupt |

## Verification
The assertions assume that every primed maximum packet size is nonzero. With a zero size, no packet could count as short and the zero-length end rule would not hold. They also assume that `pkt_valid_i` is a single-cycle pulse per packet. The stimulus always primes with sizes of 8 or 64 bytes and drives each packet for exactly one cycle, away from the clock edge. Coincident prime and packet events are sent only where a requirement covers them, such as a prime while armed.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic {HS_NAK = 1'b0, HS_ACK = 1'b1} hs_e;

  typedef struct packed {
    logic short_end;
    logic ovf_end;
  } end_kind_t;
endpackage

// File: rtl/ep_xfer_ctrl.sv
module ep_xfer_ctrl
  import usb_ep_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prime_i,
  input  logic [LEN_W-1:0] prime_len_i,
  input  logic [MPS_W-1:0] prime_mps_i,
  input  logic             prime_ioc_i,
  input  logic             pkt_valid_i,
  input  logic [MPS_W-1:0] pkt_len_i,
  output logic             active_o,
  output logic [LEN_W-1:0] residual_o,
  output logic             short_o,
  output logic             ovf_o,
  output logic             end_evt_o,
  output logic             irq_req_o
);
  localparam int PadW = LEN_W - MPS_W;

  logic             active_q, ioc_q, short_q, ovf_q;
  logic [LEN_W-1:0] rem_q, len_ext, rem_next;
  logic [MPS_W-1:0] mps_q;
  logic             take, too_big;
  end_kind_t        kind;

  assign len_ext   = {{PadW{1'b0}}, pkt_len_i};
  assign take      = pkt_valid_i && active_q;
  assign too_big   = (pkt_len_i > mps_q) || (len_ext > rem_q);
  assign rem_next  = rem_q - len_ext;
  assign kind.ovf_end   = too_big;
  assign kind.short_end = !too_big && (pkt_len_i < mps_q);

  assign end_evt_o = take && (kind.ovf_end || kind.short_end || rem_next == '0);
  assign irq_req_o = end_evt_o && (ioc_q || kind.ovf_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ioc_q    <= 1'b0;
      short_q  <= 1'b0;
      ovf_q    <= 1'b0;
      rem_q    <= '0;
      mps_q    <= '0;
    end else if (prime_i && !active_q) begin
      active_q <= 1'b1;
      rem_q    <= prime_len_i;
      mps_q    <= prime_mps_i;
      ioc_q    <= prime_ioc_i;
      short_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else if (take) begin
      if (kind.ovf_end) begin
        ovf_q    <= 1'b1;
        active_q <= 1'b0;
      end else begin
        rem_q   <= rem_next;
        short_q <= kind.short_end;
        if (end_evt_o) active_q <= 1'b0;
      end
    end
  end

  assign active_o   = active_q;
  assign residual_o = rem_q;
  assign short_o    = short_q;
  assign ovf_o      = ovf_q;

  AST_PRIME_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prime_i && !active_q |=> active_q && !short_q && !ovf_q); // R2
  AST_RESID_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !too_big |=> rem_q == $past(rem_q) - $past(len_ext)); // R3
  AST_SHORT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !too_big && pkt_len_i < mps_q |=> !active_q && short_q); // R4
  AST_ZERO_RESID_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && pkt_len_i == mps_q && len_ext == rem_q |=> !active_q && !short_q && rem_q == '0); // R5
  AST_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && too_big |=> ovf_q && !active_q && $stable(rem_q)); // R7
  AST_PRIME_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && prime_i && !pkt_valid_i |=> $stable(rem_q) && $stable(mps_q) && active_q); // R9
  AST_ZLP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && pkt_len_i == '0 && rem_q != '0 |=> !active_q && short_q); // R10
endmodule

// File: rtl/ep_hs_resp.sv
module ep_hs_resp
  import usb_ep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pkt_valid_i,
  input  logic armed_i,
  output logic hs_valid_o,
  output logic hs_ack_o
);
  logic hs_valid_q;
  hs_e  hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_valid_q <= 1'b0;
      hs_q       <= HS_NAK;
    end else begin
      hs_valid_q <= pkt_valid_i;
      hs_q       <= (pkt_valid_i && armed_i) ? HS_ACK : HS_NAK;
    end
  end

  assign hs_valid_o = hs_valid_q;
  assign hs_ack_o   = (hs_q == HS_ACK);

  AST_NAK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && !armed_i |=> hs_valid_o && !hs_ack_o); // R1
  AST_ACK_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && armed_i |=> hs_valid_o && hs_ack_o); // R3
endmodule

// File: rtl/ep_irq_flag.sv
module ep_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;  // set beats a coincident clear
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_i |=> irq_q); // R8
  AST_IRQ_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && clr_i |=> irq_q); // R8
endmodule

// File: rtl/usb_out_ep_tracker.sv
module usb_out_ep_tracker #(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prime_i,
  input  logic [LEN_W-1:0] prime_len_i,
  input  logic [MPS_W-1:0] prime_mps_i,
  input  logic             prime_ioc_i,
  input  logic             irq_clr_i,
  input  logic             pkt_valid_i,
  input  logic [MPS_W-1:0] pkt_len_i,
  output logic             hs_valid_o,
  output logic             hs_ack_o,
  output logic             active_o,
  output logic [LEN_W-1:0] residual_o,
  output logic             short_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic end_evt, irq_req;

  ep_xfer_ctrl #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_ctrl (
    .clk_i, .rst_ni, .prime_i, .prime_len_i, .prime_mps_i, .prime_ioc_i,
    .pkt_valid_i, .pkt_len_i, .active_o, .residual_o, .short_o, .ovf_o,
    .end_evt_o(end_evt), .irq_req_o(irq_req)
  );

  ep_hs_resp u_hs (
    .clk_i, .rst_ni, .pkt_valid_i, .armed_i(active_o),
    .hs_valid_o, .hs_ack_o
  );

  ep_irq_flag u_irq (
    .clk_i, .rst_ni, .set_i(irq_req), .clr_i(irq_clr_i), .irq_o
  );

  AST_IRQ_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(active_o) && !active_o); // R6
  AST_NO_MIDXFER_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && active_o && !end_evt && !irq_o |=> !irq_o); // R6
  AST_OVF_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> irq_o); // R7
  AST_NAK_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_evt |=> !active_o); // R11
endmodule

// File: tb/tb_usb_out_ep_tracker.sv
`timescale 1ns/1ps
module tb_usb_out_ep_tracker;
  localparam int LEN_W = 16;
  localparam int MPS_W = 11;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             prime_i = 1'b0;
  logic [LEN_W-1:0] prime_len_i = '0;
  logic [MPS_W-1:0] prime_mps_i = '0;
  logic             prime_ioc_i = 1'b0;
  logic             irq_clr_i = 1'b0;
  logic             pkt_valid_i = 1'b0;
  logic [MPS_W-1:0] pkt_len_i = '0;
  logic             hs_valid_o, hs_ack_o, active_o, short_o, ovf_o, irq_o;
  logic [LEN_W-1:0] residual_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  usb_out_ep_tracker #(.LEN_W(LEN_W), .MPS_W(MPS_W)) dut (
    .clk_i(clk), .rst_ni, .prime_i, .prime_len_i, .prime_mps_i, .prime_ioc_i,
    .irq_clr_i, .pkt_valid_i, .pkt_len_i, .hs_valid_o, .hs_ack_o, .active_o,
    .residual_o, .short_o, .ovf_o, .irq_o
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive after negedge, sample at the next negedge (one register later)
  task automatic prime(int len, int mps, bit ioc);
    @(negedge clk);
    prime_i = 1'b1; prime_len_i = LEN_W'(len); prime_mps_i = MPS_W'(mps); prime_ioc_i = ioc;
    @(negedge clk);
    prime_i = 1'b0;
  endtask

  task automatic pkt(int len);
    @(negedge clk);
    pkt_valid_i = 1'b1; pkt_len_i = MPS_W'(len);
    @(negedge clk);
    pkt_valid_i = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset active", int'(active_o), 0);
    chk("R6 reset irq", int'(irq_o), 0);
    chk("R7 reset ovf", int'(ovf_o), 0);
  endtask

  task automatic t_nak_idle();
    pkt(16);
    chk("R1 hs_valid", int'(hs_valid_o), 1);
    chk("R1 NAK", int'(hs_ack_o), 0);
    chk("R1 residual", int'(residual_o), 0);
  endtask

  task automatic t_full_end();
    prime(128, 64, 1'b1);
    chk("R2 active", int'(active_o), 1);
    chk("R2 residual", int'(residual_o), 128);
    pkt(64);
    chk("R3 ACK", int'(hs_ack_o), 1);
    chk("R3 residual", int'(residual_o), 64);
    chk("R6 no mid irq", int'(irq_o), 0);
    pkt(64);
    chk("R5 ended", int'(active_o), 0);
    chk("R5 short", int'(short_o), 0);
    chk("R5 residual", int'(residual_o), 0);
    chk("R6 irq", int'(irq_o), 1);
    pkt(8);
    chk("R11 NAK after end", int'(hs_ack_o), 0);
    chk("R8 sticky", int'(irq_o), 1);
    clear_irq();
    chk("R8 cleared", int'(irq_o), 0);
  endtask

  task automatic t_short_no_ioc();
    prime(200, 64, 1'b0);
    pkt(64);
    pkt(20);
    chk("R4 ended", int'(active_o), 0);
    chk("R4 short", int'(short_o), 1);
    chk("R4 residual", int'(residual_o), 116);
    chk("R6 no ioc no irq", int'(irq_o), 0);
  endtask

  task automatic t_overflow();
    prime(32, 64, 1'b0);
    chk("R2 short cleared", int'(short_o), 0);
    pkt(40);
    chk("R7 ovf", int'(ovf_o), 1);
    chk("R7 ended", int'(active_o), 0);
    chk("R7 irq", int'(irq_o), 1);
    chk("R7 residual kept", int'(residual_o), 32);
    clear_irq();
    prime(100, 8, 1'b0);
    chk("R2 ovf cleared", int'(ovf_o), 0);
    pkt(9);
    chk("R7 over mps", int'(ovf_o), 1);
    clear_irq();
  endtask

  task automatic t_zlp();
    prime(24, 8, 1'b1);
    pkt(8);
    pkt(0);
    chk("R10 ended", int'(active_o), 0);
    chk("R10 short", int'(short_o), 1);
    chk("R10 residual", int'(residual_o), 16);
    clear_irq();
  endtask

  task automatic t_prime_ignored();
    prime(64, 8, 1'b0);
    prime(500, 64, 1'b1);
    chk("R9 residual kept", int'(residual_o), 64);
    pkt(8);
    chk("R9 mps kept", int'(residual_o), 56);
    chk("R9 still active", int'(active_o), 1);
    pkt(4);
    chk("R9 ioc kept", int'(irq_o), 0);
  endtask

  task automatic t_clear_race();
    prime(8, 8, 1'b1);
    pkt(8);
    chk("R6 irq set", int'(irq_o), 1);
    prime(8, 8, 1'b1);
    @(negedge clk);
    pkt_valid_i = 1'b1; pkt_len_i = 8; irq_clr_i = 1'b1;
    @(negedge clk);
    pkt_valid_i = 1'b0; irq_clr_i = 1'b0;
    chk("R8 set wins", int'(irq_o), 1);
    clear_irq();
    chk("R8 clr", int'(irq_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_nak_idle();
    t_full_end();
    t_short_no_ioc();
    t_overflow();
    t_zlp();
    t_prime_ignored();
    t_clear_race();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule